// File: doc/BRIEF.md
# Oscillator Tap Modulator

This block drives the tap selection of a digitally controlled oscillator one clock cycle at a time. The block is clocked by the oscillator's own output. It holds three settings:
- a range-select code, with 16 ranges where each range overlaps the next one up;
- a coarse tap code that moves the frequency in fixed steps inside a range;
- a modulation count.

Each frame is 32 output cycles long. In every frame, the block picks the next-higher tap on exactly as many cycles as the modulation count says. On every other cycle it picks the base tap. The average frequency therefore lands between two neighbouring taps.

The higher-tap cycles are spread evenly through the frame, not bunched together. A cycle with frame phase p uses the higher tap when the bit-reversed value of p is below the modulation count. Settings arrive through a write strobe at any time. They take effect only at the start of the following frame, so a frame is never built from a mix of old and new settings. A one-cycle strobe marks the first cycle of each frame.

Top module: `dcomod_top`

## Requirements
- R1: `frame_start` is high for exactly one cycle in every 32, on frame phase 0. The first cycle after reset is phase 0.
- R2: Within each frame, `tap_up` is high on exactly as many cycles as the active modulation count (0 to 31).
- R3: On every cycle where `tap_up` is low, `osc_tap` equals the active coarse tap. Where `tap_up` is high, `osc_tap` equals that tap plus one.
- R4: A modulation count of 0 holds `tap_up` low for the whole frame.
- R5: `tap_up` is high at phase p (0..31) exactly when the 5-bit bit-reversal of p is less than the modulation count. As a result, phase 31 never uses the higher tap, and a count of 16 or less never gives two higher-tap cycles in a row.
- R6: When the active coarse tap is at its maximum code (7), `tap_up` stays low and `osc_tap` stays 7 for the whole frame, whatever the modulation count is.
- R7: A write (`cfg_we` high at a clock edge) becomes active at the next frame start. This includes a write on phase 31, which takes effect on the phase 0 that follows directly. The frame in progress keeps its settings.
- R8: `osc_range` presents the active range code unchanged, for all 16 values.
- R9: After reset, the active and pending settings are range 0, tap 0 and modulation 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator output clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the pending settings |
| cfg_range | input | 4 | Range code to write |
| cfg_tap | input | 3 | Coarse tap code to write |
| cfg_mod | input | 5 | Modulation count to write |
| osc_range | output | 4 | Active range code |
| osc_tap | output | 3 | Tap selected for this cycle |
| tap_up | output | 1 | High when this cycle uses the next-higher tap |
| frame_start | output | 1 | One-cycle strobe on phase 0 of each frame |

## Verification
The bench uses the default widths: a 5-bit modulation count (a 32-cycle frame), a 3-bit tap and a 4-bit range. With these values, every phase of every frame is compared against a behavioural model, including the extreme counts 0, 16 and 31. The bench writes settings mid-frame and on the last phase of a frame, which tests the frame-boundary loading. The 3-bit tap makes the maximum tap code 7, so the forced-off case is easy to reach.

// File: rtl/dcomod_pkg.sv
package dcomod_pkg;
    parameter int RANGE_W = 4;
    parameter int TAP_W   = 3;
    parameter int MOD_W   = 5;
    localparam int FRAME_LEN = 1 << MOD_W;

    typedef struct packed {
        logic [RANGE_W-1:0] rng;
        logic [TAP_W-1:0]   tap;
        logic [MOD_W-1:0]   mod;
    } dco_cfg_t;

    localparam logic [TAP_W-1:0] TAP_TOP = {TAP_W{1'b1}};
    localparam logic [MOD_W-1:0] PHASE_LAST = {MOD_W{1'b1}};

    function automatic logic [MOD_W-1:0] bit_rev(input logic [MOD_W-1:0] v);
        logic [MOD_W-1:0] r;
        for (int i = 0; i < MOD_W; i++) r[i] = v[MOD_W-1-i];
        return r;
    endfunction
endpackage

// File: rtl/dcomod_phase.sv
module dcomod_phase
    import dcomod_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    output logic [MOD_W-1:0] phase,
    output logic             frame_start,
    output logic             frame_last
);
    always_ff @(posedge clk) begin
        if (rst) phase <= '0;
        else     phase <= phase + 1'b1;
    end

    assign frame_start = (phase == '0);
    assign frame_last  = (phase == PHASE_LAST);

    assert_strobe_single_R1: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start);
    assert_last_then_start_R1: assert property (@(posedge clk) disable iff (rst)
        frame_last |=> frame_start);
endmodule

// File: rtl/dcomod_regs.sv
module dcomod_regs
    import dcomod_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     we,
    input  dco_cfg_t wr_cfg,
    input  logic     frame_last,
    output dco_cfg_t active
);
    dco_cfg_t pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= '0;
            active  <= '0;
        end else begin
            if (we) pending <= wr_cfg;
            if (frame_last) active <= we ? wr_cfg : pending;
        end
    end

    // R7: settings never move in the middle of a frame
    assert_hold_midframe_R7: assert property (@(posedge clk) disable iff (rst)
        !frame_last |=> $stable(active));
endmodule

// File: rtl/dcomod_pattern.sv
module dcomod_pattern
    import dcomod_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [MOD_W-1:0] phase,
    input  logic             frame_last,
    input  dco_cfg_t         active,
    output logic             tap_up,
    output logic [TAP_W-1:0] tap_sel
);
    logic mod_allowed;
    logic [MOD_W:0] up_cnt;

    assign mod_allowed = (active.tap != TAP_TOP);
    assign tap_up  = mod_allowed && (bit_rev(phase) < active.mod);
    assign tap_sel = active.tap + {{(TAP_W-1){1'b0}}, tap_up};

    always_ff @(posedge clk) begin
        if (rst)             up_cnt <= '0;
        else if (frame_last) up_cnt <= '0;
        else                 up_cnt <= up_cnt + {{MOD_W{1'b0}}, tap_up};
    end

    assert_frame_count_R2: assert property (@(posedge clk) disable iff (rst)
        frame_last |-> (up_cnt + {{MOD_W{1'b0}}, tap_up}) ==
                       (mod_allowed ? {1'b0, active.mod} : '0));
    assert_mod0_base_R4: assert property (@(posedge clk) disable iff (rst)
        (active.mod == '0) |-> !tap_up);
    assert_spread_R5: assert property (@(posedge clk) disable iff (rst)
        (tap_up && active.mod <= MOD_W'(FRAME_LEN/2)) |=> !tap_up);
    assert_top_tap_off_R6: assert property (@(posedge clk) disable iff (rst)
        (active.tap == TAP_TOP) |-> (tap_sel == TAP_TOP));
endmodule

// File: rtl/dcomod_top.sv
module dcomod_top
    import dcomod_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [RANGE_W-1:0] cfg_range,
    input  logic [TAP_W-1:0]   cfg_tap,
    input  logic [MOD_W-1:0]   cfg_mod,
    output logic [RANGE_W-1:0] osc_range,
    output logic [TAP_W-1:0]   osc_tap,
    output logic               tap_up,
    output logic               frame_start
);
    logic [MOD_W-1:0] phase;
    logic             frame_last;
    dco_cfg_t         wr_cfg, active;

    assign wr_cfg = '{rng: cfg_range, tap: cfg_tap, mod: cfg_mod};

    dcomod_phase u_phase (
        .clk(clk), .rst(rst), .phase(phase),
        .frame_start(frame_start), .frame_last(frame_last)
    );

    dcomod_regs u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .wr_cfg(wr_cfg),
        .frame_last(frame_last), .active(active)
    );

    dcomod_pattern u_pattern (
        .clk(clk), .rst(rst), .phase(phase), .frame_last(frame_last),
        .active(active), .tap_up(tap_up), .tap_sel(osc_tap)
    );

    assign osc_range = active.rng;

    // R8: the range code only changes when a new frame begins
    assert_range_at_frame_R8: assert property (@(posedge clk) disable iff (rst)
        !frame_start |-> $stable(osc_range));
endmodule

// File: tb/dcomod_top_test.sv
module dcomod_top_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 1'b0;
    logic [3:0] cfg_range = '0;
    logic [2:0] cfg_tap = '0;
    logic [4:0] cfg_mod = '0;
    logic [3:0] osc_range;
    logic [2:0] osc_tap;
    logic tap_up, frame_start;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    // behavioural model state
    int m_phase = 0;
    int p_rng = 0, p_tap = 0, p_mod = 0;
    int a_rng = 0, a_tap = 0, a_mod = 0;
    int up_seen = 0;
    string tag = "R3";

    always #4 clk = ~clk;

    dcomod_top uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_range(cfg_range),
        .cfg_tap(cfg_tap), .cfg_mod(cfg_mod), .osc_range(osc_range),
        .osc_tap(osc_tap), .tap_up(tap_up), .frame_start(frame_start)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s phase=%0d actual=%0d expected=%0d", req, m_phase, act, exp);
        end
    endtask

    function automatic int rev5(input int p);
        int r = 0;
        for (int i = 0; i < 5; i++) if ((p >> i) & 1) r += 1 << (4 - i);
        return r;
    endfunction

    // compare at negedge, drive, advance model, wait one cycle
    task automatic cyc(input bit we, input int r, input int t, input int m);
        bit exp_up;
        exp_up = (a_tap != 7) && (rev5(m_phase) < a_mod);
        check("R1", int'(frame_start), int'(m_phase == 0));
        check("R8", int'(osc_range), a_rng);
        check(tag, int'(tap_up), int'(exp_up));
        check(tag, int'(osc_tap), a_tap + int'(exp_up));
        if (a_mod == 0) check("R4", int'(tap_up), 0);
        if (a_tap == 7) check("R6", int'(osc_tap), 7);
        up_seen += int'(tap_up);
        if (m_phase == 31) begin
            check("R2", up_seen, (a_tap == 7) ? 0 : a_mod);
            up_seen = 0;
        end
        cfg_we = we; cfg_range = 4'(r); cfg_tap = 3'(t); cfg_mod = 5'(m);
        if (m_phase == 31) begin
            if (we) begin a_rng = r; a_tap = t; a_mod = m; end
            else    begin a_rng = p_rng; a_tap = p_tap; a_mod = p_mod; end
        end
        if (we) begin p_rng = r; p_tap = t; p_mod = m; end
        m_phase = (m_phase + 1) % 32;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0);
    endtask

    // write at the current phase, then run to the end of the following frame
    task automatic set_and_run(input int r, input int t, input int m, input string req);
        tag = req;
        cyc(1, r, t, m);
        while (m_phase != 0) cyc(0, 0, 0, 0);
        idle(64);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R9: reset state visible at the ports
        check("R9", int'(osc_range), 0);
        check("R9", int'(osc_tap), 0);
        check("R9", int'(tap_up), 0);
        check("R1", int'(frame_start), 1);
        tag = "R9";
        idle(40);
        set_and_run(3, 2, 5, "R3");
        set_and_run(15, 4, 0, "R4");
        set_and_run(9, 1, 31, "R2");
        set_and_run(6, 0, 16, "R5");
        set_and_run(12, 7, 10, "R6");
        set_and_run(0, 3, 1, "R5");
        // R7: a mid-frame write leaves the current frame untouched
        tag = "R7";
        while (m_phase != 13) cyc(0, 0, 0, 0);
        cyc(1, 5, 5, 20);
        idle(50);
        // R7: a write on the last phase applies on the very next phase 0
        while (m_phase != 31) cyc(0, 0, 0, 0);
        cyc(1, 10, 6, 7);
        idle(40);
        // R8: a sweep over all ranges
        tag = "R8";
        for (int r = 0; r < 16; r++) begin
            while (m_phase != 31) cyc(0, 0, 0, 0);
            cyc(1, r, r % 7, (r * 3) % 32);
        end
        idle(40);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule